// File: doc/BRIEF.md
# SPI Word Buffer and Event Unit

This block sits between a register bus and the serial shift engine of an SPI controller. It buffers outgoing words in an eight-entry transmit queue and incoming words in an eight-entry receive queue, each 32 bits wide. Software fills the transmit queue and drains the receive queue through a single data address. The shift engine takes words from the head of the transmit queue and delivers received words one at a time. The unit turns queue fill levels and engine activity into status flags, sticky interrupt events, one interrupt line and two level-style DMA request lines.

Two 4-bit fill thresholds set when events fire. The receive threshold controls the receive-complete event, the receive level flag and the receive DMA request. The transmit threshold controls the transmit DMA request. Each queue can be emptied in a single cycle by writing a self-clearing flush bit. Serial timing and bit shifting belong to the engine and are outside this unit.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: Each queue holds 8 words and keeps arrival order. A write to byte offset 0x10 pushes the transmit queue. A write made while the transmit queue already holds 8 words is discarded.
- R2: A read at offset 0x10 returns the oldest receive word and removes it. With the receive queue empty, the read returns 0 and changes nothing.
- R3: At offset 0x00, writing bit 12 empties the transmit queue and writing bit 4 empties the receive queue, both at that clock edge. These two bits always read back 0. Bits 11:8 hold the transmit threshold and bits 3:0 hold the receive threshold. After reset the register reads 0x0001.
- R4: Status at offset 0x04 shows bit 0 = receive queue not empty and bit 7 = the engine busy input.
- R5: At offset 0x0C, bit 9 reads 1 while the receive fill level is at or above the receive threshold. Bits 4, 3 and 0 show the pending transmit-complete, receive-complete and overrun events.
- R6: A word delivered by the engine while the receive queue holds 8 words is dropped, and the overrun event (bit 0) becomes pending.
- R7: The receive-complete event (bit 3) becomes pending one edge after all three hold together: the receive level is at or above the threshold, the transmit queue is empty, and the engine is idle.
- R8: The transmit-complete event (bit 4) becomes pending at the first edge where the busy input is low after being high, provided the transmit queue is empty.
- R9: Writing 1 to bits 4, 3 or 0 at offset 0x0C clears the matching pending event. A pending event stays set until it is cleared. If a set condition and a clear fall in the same cycle, the event stays set.
- R10: The interrupt enable register at offset 0x08 uses bit 4 = transmit complete, bit 3 = receive complete, bit 2 = transmit DMA, bit 1 = receive DMA, bit 0 = overrun. The irq output is high exactly when some pending event has its enable bit set.
- R11: tx_dma_req is high while the transmit fill level is at or below the transmit threshold and enable bit 2 is set. rx_dma_req is high while the receive fill level is at or above the receive threshold and enable bit 1 is set.
- R12: eng_tx_valid is high while the transmit queue holds a word, and eng_tx_data shows its oldest word. Each cycle with eng_tx_take high removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at 0x10) |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_tx_valid | output | 1 | Transmit word available to engine |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_take | input | 1 | Engine consumes transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_busy | input | 1 | Engine is shifting |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |

## Verification
Queue contents, thresholds and enables change at the edge of the strobe that writes them. The status word, the level flag, both DMA requests, the read data and the irq line follow that state combinationally, so they are valid right after that edge. Pending events take one more edge: overrun and transmit-complete latch at the edge where their cause is present, and receive-complete latches one edge after its level condition appears. Inputs are driven on falling edges and read back through the read data at the next falling edge. Before any event flag is checked, the bench waits one extra falling edge.

// File: rtl/spi_fu_pkg.sv
package spi_fu_pkg;

    // byte offsets of the register window
    localparam logic [4:0] OFS_FCTL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_IEN  = 5'h08;
    localparam logic [4:0] OFS_EVT  = 5'h0C;
    localparam logic [4:0] OFS_DATA = 5'h10;

    // queue control field positions
    localparam int TX_FLUSH_BIT = 12;
    localparam int RX_FLUSH_BIT = 4;
    localparam int TX_THR_LSB   = 8;
    localparam int RX_THR_LSB   = 0;

    // status positions
    localparam int ST_RXNE_BIT = 0;
    localparam int ST_BUSY_BIT = 7;

    // event / enable positions
    localparam int EV_TXC_BIT  = 4;
    localparam int EV_RXC_BIT  = 3;
    localparam int EN_TXD_BIT  = 2;
    localparam int EN_RXD_BIT  = 1;
    localparam int EV_OVR_BIT  = 0;
    localparam int EV_LVL_BIT  = 9;

    localparam int IEN_W = 5;

    typedef struct packed {
        logic txc;
        logic rxc;
        logic ovr;
    } pend_t;

endpackage

// File: rtl/spi_fu_fifo.sv
module spi_fu_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp           = step(st_q.wp);
            end
            if (do_pop) begin
                st_d.rp = step(st_q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH))
        else $error("fill level above depth");

    assert_full_push_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(count)))
        else $error("push into full queue changed level");

    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty)
        else $error("flush did not empty queue");

endmodule

// File: rtl/spi_fu_events.sv
module spi_fu_events
    import spi_fu_pkg::*;
#(
    parameter int CW    = 4,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    tx_cnt,
    input  logic [CW-1:0]    rx_cnt,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic             busy,
    input  logic             ovr_evt,
    input  pend_t            clr,
    input  logic [IEN_W-1:0] ien,
    output pend_t            pend,
    output logic             rx_hit,
    output logic             irq,
    output logic             tx_dreq,
    output logic             rx_dreq
);
    localparam int CMPW = (CW > THR_W) ? CW : THR_W;

    typedef struct packed {
        pend_t pend;
        logic  busy_prev;
    } ev_st_t;

    ev_st_t st_d, st_q;

    logic [CMPW-1:0] tx_w, rx_w, txt_w, rxt_w;
    logic            tx_empty, rxc_cond, txc_cond;

    assign tx_w  = CMPW'(tx_cnt);
    assign rx_w  = CMPW'(rx_cnt);
    assign txt_w = CMPW'(tx_thr);
    assign rxt_w = CMPW'(rx_thr);

    assign rx_hit   = (rx_w >= rxt_w);
    assign tx_empty = (tx_cnt == '0);
    assign rxc_cond = rx_hit && tx_empty && !busy;
    assign txc_cond = st_q.busy_prev && !busy && tx_empty;

    assign tx_dreq = (tx_w <= txt_w) && ien[EN_TXD_BIT];
    assign rx_dreq = rx_hit && ien[EN_RXD_BIT];

    assign pend = st_q.pend;
    assign irq  = (st_q.pend.txc && ien[EV_TXC_BIT]) ||
                  (st_q.pend.rxc && ien[EV_RXC_BIT]) ||
                  (st_q.pend.ovr && ien[EV_OVR_BIT]);

    always_comb begin
        st_d           = st_q;
        st_d.busy_prev = busy;
        // a set in the same cycle as a clear wins
        st_d.pend.ovr  = ovr_evt  || (st_q.pend.ovr && !clr.ovr);
        st_d.pend.rxc  = rxc_cond || (st_q.pend.rxc && !clr.rxc);
        st_d.pend.txc  = txc_cond || (st_q.pend.txc && !clr.txc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_overrun_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> pend.ovr)
        else $error("overrun not recorded");

    assert_rxc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.rxc && !clr.rxc) |=> pend.rxc)
        else $error("receive-complete dropped without clear");

    assert_txc_on_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && tx_empty) |=> pend.txc)
        else $error("transmit-complete missed on idle");

endmodule

// File: rtl/spi_fifo_evt_unit.sv
module spi_fifo_evt_unit
    import spi_fu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int AW    = 5,
    parameter int THR_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          eng_tx_valid,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_tx_take,
    input  logic          eng_rx_valid,
    input  logic [DW-1:0] eng_rx_data,
    input  logic          eng_busy,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic [IEN_W-1:0] ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic          hit_fctl, hit_ien, hit_evt, hit_data;
    logic          tx_flush, rx_flush, tx_push, rx_pop, ovr_evt;
    logic [DW-1:0] tx_head, rx_head;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          rx_hit;
    pend_t         clr, pend;

    assign hit_fctl = (bus_addr == AW'(OFS_FCTL));
    assign hit_ien  = (bus_addr == AW'(OFS_IEN));
    assign hit_evt  = (bus_addr == AW'(OFS_EVT));
    assign hit_data = (bus_addr == AW'(OFS_DATA));

    assign tx_flush = bus_wr && hit_fctl && bus_wdata[TX_FLUSH_BIT];
    assign rx_flush = bus_wr && hit_fctl && bus_wdata[RX_FLUSH_BIT];
    assign tx_push  = bus_wr && hit_data;
    assign rx_pop   = bus_rd && hit_data;
    assign ovr_evt  = eng_rx_valid && rx_full;

    always_comb begin
        clr     = '0;
        clr.txc = bus_wr && hit_evt && bus_wdata[EV_TXC_BIT];
        clr.rxc = bus_wr && hit_evt && bus_wdata[EV_RXC_BIT];
        clr.ovr = bus_wr && hit_evt && bus_wdata[EV_OVR_BIT];
    end

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr && hit_fctl) begin
            cfg_d.tx_thr = bus_wdata[TX_THR_LSB +: THR_W];
            cfg_d.rx_thr = bus_wdata[RX_THR_LSB +: THR_W];
        end
        if (bus_wr && hit_ien) begin
            cfg_d.ien = bus_wdata[IEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.rx_thr <= THR_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    spi_fu_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (bus_wdata),
        .pop       (eng_tx_take),
        .head      (tx_head),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spi_fu_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_valid),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    spi_fu_events #(.CW(CW), .THR_W(THR_W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_cnt  (tx_cnt),
        .rx_cnt  (rx_cnt),
        .tx_thr  (cfg_q.tx_thr),
        .rx_thr  (cfg_q.rx_thr),
        .busy    (eng_busy),
        .ovr_evt (ovr_evt),
        .clr     (clr),
        .ien     (cfg_q.ien),
        .pend    (pend),
        .rx_hit  (rx_hit),
        .irq     (irq),
        .tx_dreq (tx_dma_req),
        .rx_dreq (rx_dma_req)
    );

    assign eng_tx_valid = !tx_empty;
    assign eng_tx_data  = tx_head;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_FCTL): begin
                bus_rdata[TX_THR_LSB +: THR_W] = cfg_q.tx_thr;
                bus_rdata[RX_THR_LSB +: THR_W] = cfg_q.rx_thr;
            end
            AW'(OFS_STAT): begin
                bus_rdata[ST_RXNE_BIT] = !rx_empty;
                bus_rdata[ST_BUSY_BIT] = eng_busy;
            end
            AW'(OFS_IEN): bus_rdata[IEN_W-1:0] = cfg_q.ien;
            AW'(OFS_EVT): begin
                bus_rdata[EV_LVL_BIT] = rx_hit;
                bus_rdata[EV_TXC_BIT] = pend.txc;
                bus_rdata[EV_RXC_BIT] = pend.rxc;
                bus_rdata[EV_OVR_BIT] = pend.ovr;
            end
            AW'(OFS_DATA): bus_rdata = rx_empty ? '0 : rx_head;
            default: bus_rdata = '0;
        endcase
    end

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ien == '0) |-> !irq)
        else $error("interrupt with all enables off");

    assert_empty_read_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty && !eng_rx_valid) |=> rx_empty)
        else $error("read of empty receive queue changed it");

endmodule

// File: tb/tb_spi_fifo_evt_unit.sv
module tb_spi_fifo_evt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eng_tx_valid, eng_tx_take = 1'b0;
    logic [31:0] eng_tx_data, eng_rx_data = '0;
    logic        eng_rx_valid = 1'b0, eng_busy = 1'b0;
    logic        irq, tx_dma_req, rx_dma_req;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_fifo_evt_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    localparam logic [4:0] A_FCTL = 5'h00, A_STAT = 5'h04, A_IEN = 5'h08,
                           A_EVT = 5'h0C, A_DATA = 5'h10;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic eng_push(input logic [31:0] w);
        @(negedge clk); eng_rx_valid = 1'b1; eng_rx_data = w;
        @(negedge clk); eng_rx_valid = 1'b0;
    endtask

    task automatic eng_take(output logic [31:0] w);
        @(negedge clk); #1 w = eng_tx_data; eng_tx_take = 1'b1;
        @(negedge clk); eng_tx_take = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(A_FCTL, v); chk("R3", "reset fctl", v, 32'h1);
        peek(A_STAT, v); chk("R4", "reset status", v, 32'h0);
        peek(A_EVT, v);  chk("R5", "reset events", v, 32'h0);
        chk("R10", "reset irq", irq, 1'b0);
        chk("R11", "reset dma", {tx_dma_req, rx_dma_req}, 2'b00);
        chk("R12", "reset tx valid", eng_tx_valid, 1'b0);
    endtask

    task automatic t_tx_order();
        logic [31:0] w;
        for (int i = 0; i < 3; i++) wr(A_DATA, 32'h1000 + i);
        chk("R12", "tx valid after writes", eng_tx_valid, 1'b1);
        for (int i = 0; i < 3; i++) begin
            eng_take(w);
            chk("R12", "tx order", w, 32'h1000 + i);
        end
        chk("R12", "tx valid after drain", eng_tx_valid, 1'b0);
    endtask

    task automatic t_tx_full();
        logic [31:0] w;
        for (int i = 0; i < 9; i++) wr(A_DATA, 32'hA0 + i);
        for (int i = 0; i < 8; i++) begin
            eng_take(w);
            chk("R1", "tx full keep order", w, 32'hA0 + i);
        end
        chk("R1", "ninth write dropped", eng_tx_valid, 1'b0);
    endtask

    task automatic t_rx_path();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) eng_push(32'h5500 + i);
        peek(A_STAT, v); chk("R4", "rx not empty", v, 32'h1);
        for (int i = 0; i < 3; i++) begin
            rd(A_DATA, v);
            chk("R1", "rx order", v, 32'h5500 + i);
        end
        rd(A_DATA, v); chk("R2", "empty read value", v, 32'h0);
        peek(A_STAT, v); chk("R2", "empty read no change", v, 32'h0);
        wr(A_EVT, 32'h19);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        for (int i = 0; i < 9; i++) eng_push(32'hC0 + i);
        settle();
        peek(A_EVT, v); chk("R6", "overrun pending", v[0], 1'b1);
        chk("R10", "irq masked", irq, 1'b0);
        wr(A_IEN, 32'h01);
        chk("R10", "irq overrun enabled", irq, 1'b1);
        for (int i = 0; i < 8; i++) begin
            rd(A_DATA, v);
            chk("R6", "kept words", v, 32'hC0 + i);
        end
        peek(A_STAT, v); chk("R6", "extra word dropped", v, 32'h0);
        peek(A_EVT, v); chk("R9", "overrun stays set", v[0], 1'b1);
        wr(A_EVT, 32'h19);
        peek(A_EVT, v); chk("R9", "events cleared", v, 32'h0);
        chk("R10", "irq after clear", irq, 1'b0);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) wr(A_DATA, 32'h77 + i);
        eng_push(32'h88); eng_push(32'h99);
        wr(A_FCTL, 32'h1011);
        chk("R3", "tx flushed", eng_tx_valid, 1'b0);
        peek(A_STAT, v); chk("R3", "rx flushed", v, 32'h0);
        peek(A_FCTL, v); chk("R3", "flush bits self clear", v, 32'h1);
        wr(A_EVT, 32'h19);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        wr(A_FCTL, 32'h0002);
        @(negedge clk); eng_busy = 1'b1;
        eng_push(32'h1); settle();
        peek(A_EVT, v); chk("R5", "below rx threshold", v, 32'h0);
        peek(A_STAT, v); chk("R4", "busy shown", v, 32'h81);
        eng_push(32'h2); settle();
        peek(A_EVT, v); chk("R7", "no rx complete while busy", v, 32'h200);
        eng_busy = 1'b0; settle(); settle();
        peek(A_EVT, v); chk("R8", "both completes", v, 32'h218);
        wr(A_IEN, 32'h10);
        chk("R10", "irq with txc pending enabled", irq, 1'b1);
        wr(A_EVT, 32'h10);
        chk("R10", "rxc pending but masked", irq, 1'b0);
        wr(A_IEN, 32'h08);
        chk("R10", "rxc enabled", irq, 1'b1);
        wr(A_EVT, 32'h08); settle();
        peek(A_EVT, v); chk("R9", "set wins over clear", v, 32'h208);
        rd(A_DATA, v); rd(A_DATA, v);
        wr(A_EVT, 32'h08);
        peek(A_EVT, v); chk("R9", "cleared after drain", v, 32'h0);
        wr(A_IEN, 32'h0);
        wr(A_FCTL, 32'h0001);
    endtask

    task automatic t_dma();
        logic [31:0] w;
        wr(A_FCTL, 32'h0203);
        chk("R11", "dma off before enable", {tx_dma_req, rx_dma_req}, 2'b00);
        wr(A_IEN, 32'h06);
        chk("R11", "tx req at level 0", tx_dma_req, 1'b1);
        chk("R11", "rx req at level 0", rx_dma_req, 1'b0);
        for (int i = 0; i < 3; i++) wr(A_DATA, 32'hD0 + i);
        chk("R11", "tx req above threshold", tx_dma_req, 1'b0);
        eng_take(w);
        chk("R11", "tx req at threshold", tx_dma_req, 1'b1);
        eng_push(32'hE0); eng_push(32'hE1);
        chk("R11", "rx req below threshold", rx_dma_req, 1'b0);
        eng_push(32'hE2);
        chk("R11", "rx req at threshold", rx_dma_req, 1'b1);
        wr(A_IEN, 32'h0);
        chk("R11", "reqs masked", {tx_dma_req, rx_dma_req}, 2'b00);
        wr(A_FCTL, 32'h1011);
        wr(A_EVT, 32'h19);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_order();
        t_tx_full();
        t_rx_path();
        t_overrun();
        t_flush();
        t_complete();
        t_dma();
        finished = 1;
        summary();
    end

    initial begin
        #(1_000_000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not complete");
            summary();
        end
    end
endmodule